// File: doc/BRIEF.md
# Reconfiguration Context Scheduler

The scheduler sits between a request bus and one shared reconfigurable region. The region holds at most one hardware function at a time. Each incoming request carries an address, and its upper bits select one of `NUM_FN` functions. The scheduler keeps one request in a holding register. It then decides whether to dispatch the request at once, to start loading the target function into the region, or to park the target in a first-in first-out queue until the region goes quiet.

A load is not a real bitstream transfer. It is modelled as a countdown whose length comes from the configuration size, the configuration port width and a fixed extra delay. Each function follows a five-state life cycle, reported on a packed status output. A function that is running is never interrupted. A mask fixed at elaboration marks which functions may be loaded ahead of demand when a hint arrives on the prefetch input.

Top module: `ctx_sched`

## Requirements
- R1: After reset every function reads state 0, `req_ready` is 1, and `disp_valid` and `region_loading` are 0. At no time are two functions in state 2, 3 or 4 together.
- R2: `fn_state[3f+2:3f]` reports function f using these codes: 0 unloaded, 1 queued, 2 loading, 3 loaded idle, 4 running. The upper `$clog2(NUM_FN)` bits of `req_addr` select the function, and the low `OFF_W` bits are an offset.
- R3: Suppose a request accepted at edge E0 targets an unloaded function while nothing is loading or running and the queue is empty. Then that function is in state 2 after edge E1.
- R4: A request for an unloaded function that arrives while another function runs or loads puts the target in state 1, and the target joins the queue. Queued functions are loaded, and their requests dispatched, in arrival order.
- R5: When a load ends, the function enters state 3. On the next edge its parked request is dispatched: `disp_valid` pulses for one cycle with `disp_fn` and `disp_off` taken from the request, and the function enters state 4. A cold request therefore sees `disp_valid` `LOAD_CYC+2` edges after acceptance.
- R6: A request to a function in state 3 is dispatched one edge after acceptance, with no load. A `fn_done[f]` pulse while f is in state 4 returns f to state 3.
- R7: Starting any load moves the function that was resident in state 3 back to state 0.
- R8: A function in state 4 stays there until its `fn_done` bit is seen. No load starts while any function is in state 4.
- R9: `region_loading` is high for exactly `LOAD_CYC = ceil(CFG_BITS/PORT_W) + EXTRA_CYC` cycles per load (6 with the defaults).
- R10: A `hint_valid` for function h starts its load when `PF_TABLE[h]` is 1, h is unloaded, the region is quiet and the queue is empty. The function then stays in state 3 with no dispatch until it is requested. A hint for a function whose mask bit is 0 does nothing.
- R11: `req_ready` is low while a request is held. A request for a function that is already queued or loading with a parked request is not queued again. It stays held, with `req_ready` low, until it can be dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_addr | input | $clog2(NUM_FN)+OFF_W | Function select (upper bits) and offset |
| req_ready | output | 1 | Holding register is free |
| hint_valid | input | 1 | Prefetch hint present |
| hint_fn | input | $clog2(NUM_FN) | Function named by the hint |
| fn_done | input | NUM_FN | Completion pulse per function |
| disp_valid | output | 1 | One-cycle dispatch pulse |
| disp_fn | output | $clog2(NUM_FN) | Dispatched function |
| disp_off | output | OFF_W | Offset of the dispatched request |
| region_loading | output | 1 | A load countdown is in progress |
| fn_state | output | 3*NUM_FN | Packed per-function state codes |

## Verification
The bench goes after the queue ordering. It parks two functions behind a running one, then checks that the first one parked loads and dispatches first; a design that popped the wrong end of the queue would serve them in reverse. It sends a second request for a function that is already queued. A design that queued that function twice would reload it, and one that dropped the request would never dispatch it a second time. It checks that a running function keeps its state and that no load begins while it runs, which catches a scheduler that preempts. It also measures the load window and the cold-request latency, which exposes off-by-one errors in the countdown. Finally it checks that a prefetched function sits idle with no dispatch, and that an unmasked hint changes nothing.

// File: rtl/ctx_sched_pkg.sv
package ctx_sched_pkg;

  typedef enum logic [2:0] {
    FN_UNLOADED = 3'd0,
    FN_QUEUED   = 3'd1,
    FN_LOADING  = 3'd2,
    FN_READY    = 3'd3,
    FN_ACTIVE   = 3'd4
  } fn_state_e;

  // cycles to move a configuration image through the port, plus fixed overhead
  function automatic int load_cycles(int bits, int port_w, int extra);
    return (bits + port_w - 1) / port_w + extra;
  endfunction

endpackage

// File: rtl/ctx_load_timer.sv
module ctx_load_timer #(
  parameter int LOAD_CYC = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic finish
);
  localparam int CW = $clog2(LOAD_CYC + 1);

  logic [CW-1:0] cnt;

  assign finish = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(LOAD_CYC - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/ctx_id_fifo.sv
module ctx_id_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_id,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [NW-1:0] count;

  assign head  = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == NW'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_id;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/ctx_sched.sv
module ctx_sched
  import ctx_sched_pkg::*;
#(
  parameter int                  NUM_FN    = 4,
  parameter int                  OFF_W     = 4,
  parameter int                  CFG_BITS  = 64,
  parameter int                  PORT_W    = 16,
  parameter int                  EXTRA_CYC = 2,
  parameter logic [NUM_FN-1:0]   PF_TABLE  = 4'b0100
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              req_valid,
  input  logic [$clog2(NUM_FN)+OFF_W-1:0]   req_addr,
  output logic                              req_ready,
  input  logic                              hint_valid,
  input  logic [$clog2(NUM_FN)-1:0]         hint_fn,
  input  logic [NUM_FN-1:0]                 fn_done,
  output logic                              disp_valid,
  output logic [$clog2(NUM_FN)-1:0]         disp_fn,
  output logic [OFF_W-1:0]                  disp_off,
  output logic                              region_loading,
  output logic [3*NUM_FN-1:0]               fn_state
);
  localparam int FN_W     = $clog2(NUM_FN);
  localparam int LOAD_CYC = load_cycles(CFG_BITS, PORT_W, EXTRA_CYC);

  fn_state_e         st       [NUM_FN];
  logic [OFF_W-1:0]  pend_off [NUM_FN];
  logic [NUM_FN-1:0] pend;
  logic              hold_v;
  logic [FN_W-1:0]   hold_fn, load_fn, fifo_head, load_id, pd_fn;
  logic [OFF_W-1:0]  hold_off;
  logic              any_run, pend_disp, hold_disp, region_busy;
  logic              hold_cold, hold_start, hold_queue, hold_park, hold_clear;
  logic              pop_go, hint_go, load_go;
  logic              fifo_empty, fifo_full, tmr_busy, tmr_finish;
  fn_state_e         hold_st;

  ctx_load_timer #(.LOAD_CYC(LOAD_CYC)) timer_i (
    .clk(clk), .rst(rst), .start(load_go), .busy(tmr_busy), .finish(tmr_finish)
  );

  ctx_id_fifo #(.DEPTH(NUM_FN), .W(FN_W)) queue_i (
    .clk(clk), .rst(rst), .push(hold_queue), .push_id(hold_fn),
    .pop(pop_go), .head(fifo_head), .empty(fifo_empty), .full(fifo_full)
  );

  always_comb begin
    any_run   = 1'b0;
    pend_disp = 1'b0;
    pd_fn     = '0;
    for (int f = 0; f < NUM_FN; f++) begin
      if (st[f] == FN_ACTIVE) any_run = 1'b1;
      if (st[f] == FN_READY && pend[f]) begin
        pend_disp = 1'b1;
        pd_fn     = FN_W'(f);
      end
    end
  end

  assign hold_st     = st[hold_fn];
  assign hold_disp   = hold_v && hold_st == FN_READY && !pend[hold_fn];
  assign region_busy = any_run || tmr_busy || pend_disp || hold_disp;
  assign pop_go      = !fifo_empty && !region_busy;
  assign hold_cold   = hold_v && hold_st == FN_UNLOADED;
  assign hold_start  = hold_cold && fifo_empty && !region_busy;
  assign hold_queue  = hold_cold && !hold_start && !fifo_full;
  assign hold_park   = hold_v && (hold_st == FN_QUEUED || hold_st == FN_LOADING)
                       && !pend[hold_fn];
  assign hold_clear  = hold_disp || hold_start || hold_queue || hold_park;
  assign hint_go     = hint_valid && PF_TABLE[hint_fn] && st[hint_fn] == FN_UNLOADED
                       && !region_busy && fifo_empty && !hold_cold;
  assign load_go     = pop_go || hold_start || hint_go;
  assign load_id     = pop_go ? fifo_head : (hold_start ? hold_fn : hint_fn);

  assign req_ready      = !hold_v;
  assign region_loading = tmr_busy;

  generate
    for (genvar g = 0; g < NUM_FN; g++) begin : g_state_out
      assign fn_state[3*g +: 3] = st[g];
    end
  endgenerate

  // holding register for one incoming request
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v   <= 1'b0;
      hold_fn  <= '0;
      hold_off <= '0;
    end else if (!hold_v && req_valid) begin
      hold_v   <= 1'b1;
      hold_fn  <= req_addr[FN_W+OFF_W-1 -: FN_W];
      hold_off <= req_addr[OFF_W-1:0];
    end else if (hold_clear) begin
      hold_v <= 1'b0;
    end
  end

  // per-function life cycle and parked requests
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int f = 0; f < NUM_FN; f++) begin
        st[f]       <= FN_UNLOADED;
        pend_off[f] <= '0;
      end
      pend    <= '0;
      load_fn <= '0;
    end else begin
      if (load_go) load_fn <= load_id;
      for (int f = 0; f < NUM_FN; f++) begin
        if (load_go && load_id == FN_W'(f))           st[f] <= FN_LOADING;
        else if (load_go && st[f] == FN_READY)        st[f] <= FN_UNLOADED;
        else if (tmr_finish && load_fn == FN_W'(f))   st[f] <= FN_READY;
        else if (hold_queue && hold_fn == FN_W'(f))   st[f] <= FN_QUEUED;
        else if (pend_disp && pd_fn == FN_W'(f))      st[f] <= FN_ACTIVE;
        else if (hold_disp && hold_fn == FN_W'(f))    st[f] <= FN_ACTIVE;
        else if (fn_done[f] && st[f] == FN_ACTIVE)    st[f] <= FN_READY;

        if (pend_disp && pd_fn == FN_W'(f)) begin
          pend[f] <= 1'b0;
        end else if ((hold_start || hold_queue || hold_park) && hold_fn == FN_W'(f)) begin
          pend[f]     <= 1'b1;
          pend_off[f] <= hold_off;
        end
      end
    end
  end

  // registered dispatch outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      disp_valid <= 1'b0;
      disp_fn    <= '0;
      disp_off   <= '0;
    end else begin
      disp_valid <= pend_disp || hold_disp;
      if (pend_disp) begin
        disp_fn  <= pd_fn;
        disp_off <= pend_off[pd_fn];
      end else if (hold_disp) begin
        disp_fn  <= hold_fn;
        disp_off <= hold_off;
      end
    end
  end
endmodule

// File: rtl/ctx_sched_chk.sv
module ctx_sched_chk
  import ctx_sched_pkg::*;
#(
  parameter int NUM_FN    = 4,
  parameter int CFG_BITS  = 64,
  parameter int PORT_W    = 16,
  parameter int EXTRA_CYC = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic                      disp_valid,
  input logic [$clog2(NUM_FN)-1:0] disp_fn,
  input logic [NUM_FN-1:0]         fn_done,
  input logic                      region_loading,
  input logic [3*NUM_FN-1:0]       fn_state
);
  localparam int LOAD_CYC = load_cycles(CFG_BITS, PORT_W, EXTRA_CYC);
  localparam int RW       = $clog2(LOAD_CYC + 2) + 1;

  logic [NUM_FN-1:0] occ;
  logic [RW-1:0]     ld_run;

  always_comb begin
    for (int f = 0; f < NUM_FN; f++)
      occ[f] = fn_state[3*f +: 3] >= 3'd2;
  end

  always_ff @(posedge clk) begin
    if (rst)                 ld_run <= '0;
    else if (region_loading) ld_run <= ld_run + 1'b1;
    else                     ld_run <= '0;
  end

  // R1
  single_resident_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(occ) <= 1);

  // R11
  hold_backpressure_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R5
  dispatch_runs_chk: assert property (@(posedge clk) disable iff (rst)
    disp_valid |-> fn_state[3*disp_fn +: 3] == 3'd4);

  // R9
  load_window_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(region_loading) |-> ld_run == RW'(LOAD_CYC));

  generate
    for (genvar g = 0; g < NUM_FN; g++) begin : g_fn
      // R8
      no_preempt_chk: assert property (@(posedge clk) disable iff (rst)
        (fn_state[3*g +: 3] == 3'd4 && !fn_done[g]) |=> fn_state[3*g +: 3] == 3'd4);
      // R6
      done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (fn_state[3*g +: 3] == 3'd4 && fn_done[g]) |=> fn_state[3*g +: 3] == 3'd3);
    end
  endgenerate
endmodule

bind ctx_sched ctx_sched_chk #(
  .NUM_FN(NUM_FN), .CFG_BITS(CFG_BITS), .PORT_W(PORT_W), .EXTRA_CYC(EXTRA_CYC)
) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .disp_valid(disp_valid), .disp_fn(disp_fn), .fn_done(fn_done),
  .region_loading(region_loading), .fn_state(fn_state)
);

// File: tb/ctx_sched_tb_top.sv
module ctx_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NFN  = 4;
  localparam int FW   = 2;
  localparam int OW   = 4;
  localparam int LCYC = 6;   // ceil(64/16) + 2

  localparam int VEC_N = 5;
  localparam int VEC_FN  [VEC_N] = '{0, 0, 2, 2, 1};
  localparam int VEC_OFF [VEC_N] = '{5, 9, 3, 0, 15};
  localparam int VEC_LAT [VEC_N] = '{8, 1, 8, 1, 8};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [FW+OW-1:0] req_addr = '0;
  logic req_ready;
  logic hint_valid = 1'b0;
  logic [FW-1:0] hint_fn = '0;
  logic [NFN-1:0] fn_done = '0;
  logic disp_valid;
  logic [FW-1:0] disp_fn;
  logic [OW-1:0] disp_off;
  logic region_loading;
  logic [3*NFN-1:0] fn_state;

  int checks = 0;
  int errors = 0;
  int disp_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctx_sched dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .hint_valid(hint_valid), .hint_fn(hint_fn),
    .fn_done(fn_done), .disp_valid(disp_valid), .disp_fn(disp_fn),
    .disp_off(disp_off), .region_loading(region_loading), .fn_state(fn_state)
  );

  always @(negedge clk) if (disp_valid) disp_seen++;

  function automatic int stf(int f);
    return int'(fn_state[3*f +: 3]);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input int fn, input int off);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = {FW'(fn), OW'(off)};
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_disp(output int fn, output int off, output int lat);
    lat = 0;
    while (!disp_valid && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    fn  = int'(disp_fn);
    off = int'(disp_off);
  endtask

  task automatic finish_fn(input int fn);
    @(negedge clk);
    fn_done[fn] = 1'b1;
    @(negedge clk);
    fn_done = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int fn, off, lat, cnt, d0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(fn_state == '0, "R1 states", int'(fn_state), 0);
    chk(req_ready && !disp_valid && !region_loading, "R1 outputs", int'(req_ready), 1);

    // vector table: request, dispatch latency, completion
    for (int v = 0; v < VEC_N; v++) begin
      send(VEC_FN[v], VEC_OFF[v]);
      wait_disp(fn, off, lat);
      chk(lat == VEC_LAT[v], "R5/R6/R9 latency", lat, VEC_LAT[v]);
      chk(fn == VEC_FN[v] && off == VEC_OFF[v], "R5 dispatch fields", fn*16+off,
          VEC_FN[v]*16+VEC_OFF[v]);
      chk(stf(VEC_FN[v]) == 4, "R2 running", stf(VEC_FN[v]), 4);
      finish_fn(VEC_FN[v]);
      chk(stf(VEC_FN[v]) == 3, "R6 done to idle", stf(VEC_FN[v]), 3);
      if (v == 2) chk(stf(0) == 0, "R7 flush", stf(0), 0);
    end

    // queueing behind a running function
    send(1, 2);
    wait_disp(fn, off, lat);
    chk(fn == 1 && lat == 1, "R6 hit", lat, 1);
    send(3, 7);
    @(negedge clk);
    chk(stf(3) == 1, "R4 queued", stf(3), 1);
    chk(req_ready == 1'b1, "R11 released", int'(req_ready), 1);
    send(0, 4);
    @(negedge clk);
    chk(stf(0) == 1, "R4 queued second", stf(0), 1);
    send(3, 1);
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b0, "R11 duplicate held", int'(req_ready), 0);
    repeat (10) @(negedge clk);
    chk(stf(1) == 4 && !region_loading, "R8 no preemption", stf(1), 4);
    finish_fn(1);
    wait_disp(fn, off, lat);
    chk(fn == 3 && off == 7, "R4 order first", fn*16+off, 3*16+7);
    chk(stf(1) == 0, "R7 flush on queue pop", stf(1), 0);
    finish_fn(3);
    wait_disp(fn, off, lat);
    chk(fn == 3 && off == 1, "R11 held duplicate served", fn*16+off, 3*16+1);
    chk(stf(0) == 1, "R11 single queue entry", stf(0), 1);
    finish_fn(3);
    wait_disp(fn, off, lat);
    chk(fn == 0 && off == 4, "R4 order second", fn*16+off, 4);
    finish_fn(0);

    // prefetch through the design-time mask
    d0 = disp_seen;
    @(negedge clk);
    hint_valid = 1'b1;
    hint_fn    = 2'd2;
    @(negedge clk);
    hint_valid = 1'b0;
    chk(stf(2) == 2 && stf(0) == 0, "R10 prefetch load", stf(2), 2);
    cnt = 0;
    while (region_loading && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == LCYC, "R9 load window", cnt, LCYC);
    repeat (3) @(negedge clk);
    chk(stf(2) == 3 && disp_seen == d0, "R10 prefetch idle", disp_seen - d0, 0);
    send(2, 6);
    wait_disp(fn, off, lat);
    chk(fn == 2 && lat == 1, "R10 prefetch hit", lat, 1);
    finish_fn(2);

    @(negedge clk);
    hint_valid = 1'b1;
    hint_fn    = 2'd3;
    @(negedge clk);
    hint_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(stf(3) == 0 && !region_loading && stf(2) == 3, "R10 masked hint", stf(3), 0);

    // R3: cold request with the region quiet enters loading after one edge
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = {2'd1, 4'd0};
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(stf(1) == 2 && stf(2) == 0, "R3 immediate load", stf(1), 2);
    wait_disp(fn, off, lat);
    finish_fn(1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule